// File: doc/BRIEF.md
# Interruptible Vector Dot-Product Sequencer

This block steps a multiply-accumulate datapath through the inner product of two vectors held in word-addressed memory. A start pulse latches two base addresses, an element count and a precision choice. The block clears its accumulator and spends a fixed setup interval. It then walks the vectors one element pair at a time: it issues the memory reads, forms the signed product and adds it into the accumulator. Every element takes the same number of clocks, and that number depends only on the precision, so software can predict the total run time from N.

While a dot product runs, an interrupt request is honoured only where one element ends and the next begins. The block then stops with the remaining count and both next-element addresses held, and raises a paused flag. A resume pulse continues from the saved element with no setup and no accumulator clear, so the final result matches an uninterrupted run. A third mode evaluates a polynomial by Horner's rule. It reads coefficients from the first vector, highest degree first, and cannot be interrupted. Operands are signed two's-complement integers, and the accumulator wraps modulo 2^ACC_W.

Memory has one read port with a read latency of one clock: data for an address issued in one cycle must be valid on `mem_rdata` during the next cycle.

Top module: `vdot_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle or paused. It latches the operands, clears the accumulator and the paused flag, and reloads both pointers from the bases. A start seen while busy has no effect on the count, the pointers, the accumulator or the timing.
- R2: In single precision (`prec_dbl`=0, `mode_poly`=0), `busy` stays high for exactly 10 + 8·N clocks. `done` is then high for exactly one clock, in the first clock with `busy` low.
- R3: In double precision (`prec_dbl`=1, `mode_poly`=0), `busy` stays high for exactly 10 + 16·N clocks, followed by the same one-clock `done`.
- R4: At completion, `acc` equals the sum over the elements of the signed product of the two operands, modulo 2^ACC_W. A single-precision operand is one DATA_W-bit word. A double-precision operand is two words, with the word at the lower address as the upper half.
- R5: Each pointer advances by one word per element in single precision and by two words per element in double precision. When the block finishes, each pointer equals its base plus N times that step.
- R6: In the two dot-product modes, `irq` is sampled only in the last clock of an element, and only when at least one more element remains. When the block honours it, `busy` falls and `paused` rises. `rem_count` then holds the number of elements still to process, and `ptr_a`/`ptr_b` hold the addresses of the next element. An `irq` at any other clock has no effect.
- R7: While paused, `acc`, `ptr_a`, `ptr_b` and `rem_count` hold. A resume pulse restarts at the saved element with no setup, so `busy` stays high for exactly rem·(8 or 16) clocks. The final `acc` equals that of an uninterrupted run.
- R8: With N=0, a dot product finishes after the 10 setup clocks with `acc`=0. A polynomial with N=0 is busy for one clock and also leaves `acc`=0.
- R9: In polynomial mode (`mode_poly`=1, `prec_dbl` ignored), `busy` lasts 7·N−2 clocks for N≥1. The first coefficient is loaded into `acc`, and each later coefficient c gives `acc` ← `acc`·x + c (modulo 2^ACC_W). Here x is `poly_x` latched at start, the coefficients are single words read upward from `base_a`, and `ptr_a` ends at `base_a`+N.
- R10: In polynomial mode `irq` is ignored: `paused` never rises.
- R11: After reset, the block is idle: `busy`, `done`, `paused`, `mem_rd`, `acc`, `rem_count` and both pointers are zero.
- R12: `mem_rd` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a new operation (idle or paused only) |
| mode_poly | input | 1 | 1 = polynomial evaluation, 0 = dot product |
| prec_dbl | input | 1 | 1 = double-word operands, 0 = single-word |
| base_a | input | AW | First vector (or coefficient) base address |
| base_b | input | AW | Second vector base address |
| elem_count | input | CNT_W | Element count N |
| poly_x | input | DATA_W | Signed evaluation point for polynomial mode |
| irq | input | 1 | Interrupt request, honoured at element boundaries |
| resume | input | 1 | Continue a paused operation |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid one clock after the strobe |
| busy | output | 1 | Operation in setup or element phase |
| done | output | 1 | One-clock completion pulse |
| paused | output | 1 | Operation suspended by an interrupt |
| rem_count | output | CNT_W | Elements still to process |
| ptr_a | output | AW | Current first-vector address |
| ptr_b | output | AW | Current second-vector address |
| acc | output | ACC_W | Accumulator |

## Verification
The bench drives `irq` into the setup interval, where a block that samples it too early would stop before the first element. It holds `irq` through a resume, where a design that ignored it after resuming would never stop a second time. It also raises `irq` during a polynomial run, where a design that honoured it would wrongly pause. Resume timing and the result are compared against an uninterrupted sum. A design that repeated the setup or cleared the accumulator on resume would therefore show extra busy clocks or a short result. Zero-length runs in both modes, a start issued while busy and a start issued while paused cover the cases where a sloppy counter would underflow, where a second start would corrupt the running operation, and where a paused operation would refuse a fresh one.

// File: rtl/vdot_pkg.sv
package vdot_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ELEM  = 2'd2,
      ST_PAUSE = 2'd3
   } seq_state_e;

   // per-clock datapath strobes decoded from the element phase
   typedef struct packed {
      logic rd_a;
      logic rd_b;
      logic cap_a_hi;
      logic cap_a_lo;
      logic cap_b_hi;
      logic cap_b_lo;
      logic cap_sgl_a;
      logic cap_sgl_b;
      logic mul_dot;
      logic mul_poly;
      logic acc_add;
      logic acc_coef;
      logic acc_load;
   } step_t;

   localparam int unsigned POLY_FIRST_CYC = 5;
   localparam int unsigned POLY_NEXT_CYC  = 7;
   localparam int unsigned SGL_MIN_CYC    = 5;
   localparam int unsigned DBL_MIN_CYC    = 7;

endpackage

// File: rtl/vdot_ctrl.sv
module vdot_ctrl
   import vdot_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned SETUP_CYC = 10,
   parameter int unsigned ELEM_S    = 8,
   parameter int unsigned ELEM_D    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mode_poly,
   input  logic             prec_dbl,
   input  logic [CNT_W-1:0] elem_count,
   input  logic             irq,
   input  logic             resume,
   output logic             launch,
   output logic             busy,
   output logic             done,
   output logic             paused,
   output logic [CNT_W-1:0] rem_count,
   output step_t            step
);

   localparam int unsigned MAX_AB = (ELEM_S > ELEM_D) ? ELEM_S : ELEM_D;
   localparam int unsigned MAX_CD = (SETUP_CYC > POLY_NEXT_CYC) ? SETUP_CYC : POLY_NEXT_CYC;
   localparam int unsigned PH_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int unsigned PH_W   = $clog2(PH_MAX + 1);

   seq_state_e       state;
   logic [PH_W-1:0]  ph;
   logic [CNT_W-1:0] rem;
   logic             first;
   logic             m_poly;
   logic             m_dbl;
   int unsigned      phi;
   int unsigned      elen;
   int unsigned      slen;
   logic             elem_last;
   logic             setup_last;

   assign phi        = 32'(ph);
   assign launch     = start && (state == ST_IDLE || state == ST_PAUSE);
   assign busy       = (state == ST_SETUP) || (state == ST_ELEM);
   assign paused     = (state == ST_PAUSE);
   assign rem_count  = rem;

   always_comb begin
      if (m_poly) elen = first ? POLY_FIRST_CYC : POLY_NEXT_CYC;
      else if (m_dbl) elen = ELEM_D;
      else elen = ELEM_S;
      slen = m_poly ? 1 : SETUP_CYC;
   end

   assign elem_last  = (phi == elen - 1);
   assign setup_last = (phi == slen - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ph     <= '0;
         rem    <= '0;
         first  <= 1'b0;
         m_poly <= 1'b0;
         m_dbl  <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            m_poly <= mode_poly;
            m_dbl  <= prec_dbl;
            rem    <= elem_count;
            first  <= 1'b1;
            ph     <= '0;
            state  <= (mode_poly && elem_count != '0) ? ST_ELEM : ST_SETUP;
         end else begin
            unique case (state)
               ST_SETUP: begin
                  if (setup_last) begin
                     ph <= '0;
                     if (rem == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                     end else begin
                        state <= ST_ELEM;
                     end
                  end else begin
                     ph <= ph + PH_W'(1);
                  end
               end
               ST_ELEM: begin
                  if (elem_last) begin
                     ph    <= '0;
                     first <= 1'b0;
                     rem   <= rem - CNT_W'(1);
                     if (rem == CNT_W'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                     end else if (irq && !m_poly) begin
                        state <= ST_PAUSE;
                     end
                  end else begin
                     ph <= ph + PH_W'(1);
                  end
               end
               ST_PAUSE: begin
                  if (resume) begin
                     state <= ST_ELEM;
                     ph    <= '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // phase decode: one word read per clock, data captured a clock later
   always_comb begin
      step = '0;
      if (state == ST_ELEM) begin
         if (m_poly) begin
            step.rd_a      = (phi == 0);
            step.cap_sgl_a = (phi == 1);
            step.acc_load  = first && (phi == 2);
            step.mul_poly  = !first && (phi == 2);
            step.acc_coef  = !first && (phi == 3);
         end else if (m_dbl) begin
            step.rd_a     = (phi == 0) || (phi == 1);
            step.rd_b     = (phi == 2) || (phi == 3);
            step.cap_a_hi = (phi == 1);
            step.cap_a_lo = (phi == 2);
            step.cap_b_hi = (phi == 3);
            step.cap_b_lo = (phi == 4);
            step.mul_dot  = (phi == 5);
            step.acc_add  = (phi == 6);
         end else begin
            step.rd_a      = (phi == 0);
            step.rd_b      = (phi == 1);
            step.cap_sgl_a = (phi == 1);
            step.cap_sgl_b = (phi == 2);
            step.mul_dot   = (phi == 3);
            step.acc_add   = (phi == 4);
         end
      end
   end

endmodule

// File: rtl/vdot_agen.sv
module vdot_agen #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base_a,
   input  logic [AW-1:0] base_b,
   input  logic          rd_a,
   input  logic          rd_b,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] ptr_a,
   output logic [AW-1:0] ptr_b
);

   localparam int unsigned NCH = 2;

   logic [AW-1:0] base_v [NCH];
   logic          rd_v   [NCH];
   logic [AW-1:0] ptr_v  [NCH];

   assign base_v[0] = base_a;
   assign base_v[1] = base_b;
   assign rd_v[0]   = rd_a;
   assign rd_v[1]   = rd_b;

   // one pointer per vector, bumped by one word per issued read
   for (genvar c = 0; c < NCH; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ptr_v[c] <= '0;
         else if (load) ptr_v[c] <= base_v[c];
         else if (rd_v[c]) ptr_v[c] <= ptr_v[c] + AW'(1);
      end
   end

   assign ptr_a    = ptr_v[0];
   assign ptr_b    = ptr_v[1];
   assign mem_rd   = rd_a || rd_b;
   assign mem_addr = rd_a ? ptr_v[0] : ptr_v[1];

endmodule

// File: rtl/vdot_mac.sv
module vdot_mac
   import vdot_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ACC_W  = 72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [DATA_W-1:0] x_in,
   input  step_t             step,
   input  logic [DATA_W-1:0] rdata,
   output logic [ACC_W-1:0]  acc
);

   localparam int unsigned OPW   = 2 * DATA_W;
   localparam int unsigned PW    = 2 * OPW;
   localparam int unsigned GUARD = ACC_W - PW;

   logic [OPW-1:0]          op_a;
   logic [OPW-1:0]          op_b;
   logic [OPW-1:0]          rd_sext;
   logic [ACC_W-1:0]        prod;
   logic [ACC_W-1:0]        acc_q;
   logic [ACC_W-1:0]        x_q;
   logic signed [PW-1:0]    pd;
   logic [ACC_W-1:0]        pd_ext;
   logic [ACC_W-1:0]        coef_ext;
   logic [ACC_W-1:0]        x_ext;
   logic signed [ACC_W-1:0] pp;

   assign rd_sext  = {{DATA_W{rdata[DATA_W-1]}}, rdata};
   assign coef_ext = {{(ACC_W-OPW){op_a[OPW-1]}}, op_a};
   assign x_ext    = {{(ACC_W-DATA_W){x_in[DATA_W-1]}}, x_in};
   assign pd       = $signed(op_a) * $signed(op_b);
   assign pp       = $signed(acc_q) * $signed(x_q);

   if (GUARD == 0) begin : g_noguard
      assign pd_ext = pd;
   end else begin : g_guard
      assign pd_ext = {{GUARD{pd[PW-1]}}, pd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_a  <= '0;
         op_b  <= '0;
         prod  <= '0;
         acc_q <= '0;
         x_q   <= '0;
      end else begin
         if (step.cap_sgl_a) op_a <= rd_sext;
         if (step.cap_sgl_b) op_b <= rd_sext;
         if (step.cap_a_hi)  op_a[OPW-1:DATA_W] <= rdata;
         if (step.cap_a_lo)  op_a[DATA_W-1:0]   <= rdata;
         if (step.cap_b_hi)  op_b[OPW-1:DATA_W] <= rdata;
         if (step.cap_b_lo)  op_b[DATA_W-1:0]   <= rdata;
         if (step.mul_dot)   prod <= pd_ext;
         if (step.mul_poly)  prod <= pp;
         if (clr) begin
            acc_q <= '0;
            x_q   <= x_ext;
         end else if (step.acc_add) begin
            acc_q <= acc_q + prod;
         end else if (step.acc_coef) begin
            acc_q <= prod + coef_ext;
         end else if (step.acc_load) begin
            acc_q <= coef_ext;
         end
      end
   end

   assign acc = acc_q;

endmodule

// File: rtl/vdot_seq.sv
module vdot_seq
   import vdot_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned ACC_W     = 72,
   parameter int unsigned SETUP_CYC = 10,
   parameter int unsigned ELEM_S    = 8,
   parameter int unsigned ELEM_D    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_poly,
   input  logic              prec_dbl,
   input  logic [AW-1:0]     base_a,
   input  logic [AW-1:0]     base_b,
   input  logic [CNT_W-1:0]  elem_count,
   input  logic [DATA_W-1:0] poly_x,
   input  logic              irq,
   input  logic              resume,
   output logic              mem_rd,
   output logic [AW-1:0]     mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              paused,
   output logic [CNT_W-1:0]  rem_count,
   output logic [AW-1:0]     ptr_a,
   output logic [AW-1:0]     ptr_b,
   output logic [ACC_W-1:0]  acc
);

   localparam int unsigned MIN_ACC = 4 * DATA_W;

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("vdot_seq: SETUP_CYC must be at least 1");
   end
   if (ELEM_S < SGL_MIN_CYC) begin : g_bad_sgl
      $error("vdot_seq: ELEM_S too short for the single-word schedule");
   end
   if (ELEM_D < DBL_MIN_CYC) begin : g_bad_dbl
      $error("vdot_seq: ELEM_D too short for the double-word schedule");
   end
   if (ACC_W < MIN_ACC) begin : g_bad_acc
      $error("vdot_seq: ACC_W must hold a full double-word product");
   end
   if (CNT_W < 1 || AW < 1 || DATA_W < 2) begin : g_bad_w
      $error("vdot_seq: widths out of range");
   end

   logic  launch;
   step_t step;

   vdot_ctrl #(
      .CNT_W     (CNT_W),
      .SETUP_CYC (SETUP_CYC),
      .ELEM_S    (ELEM_S),
      .ELEM_D    (ELEM_D)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode_poly  (mode_poly),
      .prec_dbl   (prec_dbl),
      .elem_count (elem_count),
      .irq        (irq),
      .resume     (resume),
      .launch     (launch),
      .busy       (busy),
      .done       (done),
      .paused     (paused),
      .rem_count  (rem_count),
      .step       (step)
   );

   vdot_agen #(
      .AW (AW)
   ) u_agen (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch),
      .base_a   (base_a),
      .base_b   (base_b),
      .rd_a     (step.rd_a),
      .rd_b     (step.rd_b),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .ptr_a    (ptr_a),
      .ptr_b    (ptr_b)
   );

   vdot_mac #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (launch),
      .x_in  (poly_x),
      .step  (step),
      .rdata (mem_rdata),
      .acc   (acc)
   );

endmodule

// File: rtl/vdot_seq_chk.sv
module vdot_seq_chk #(
   parameter int unsigned AW    = 16,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned ACC_W = 72
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             resume,
   input logic             busy,
   input logic             done,
   input logic             paused,
   input logic             mem_rd,
   input logic [CNT_W-1:0] rem_count,
   input logic [AW-1:0]    ptr_a,
   input logic [AW-1:0]    ptr_b,
   input logic [ACC_W-1:0] acc
);

   AST_BUSY_PAUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && paused)); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R3

   AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd); // R12

   AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && !start) |=> ($stable(acc) && $stable(ptr_a) && $stable(ptr_b) && $stable(rem_count))); // R7

   AST_RESUME_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && resume && !start) |=> (busy && $stable(acc))); // R7

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (rem_count <= $past(rem_count))); // R1

endmodule

bind vdot_seq vdot_seq_chk #(.AW(AW), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/vdot_seq_test.sv
module vdot_seq_test;

   localparam int AW = 16, DW = 16, CW = 8, AC = 72;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, mode_poly = 1'b0, prec_dbl = 1'b0;
   logic [AW-1:0] base_a = '0, base_b = '0;
   logic [CW-1:0] elem_count = '0;
   logic [DW-1:0] poly_x = '0;
   logic          irq = 1'b0, resume = 1'b0;
   logic          mem_rd;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, paused;
   logic [CW-1:0] rem_count;
   logic [AW-1:0] ptr_a, ptr_b;
   logic [AC-1:0] acc;

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] mem [0:1023];

   always #10 clk = ~clk;

   vdot_seq uut (.*);

   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [AC-1:0] act, input logic [AC-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic signed [AC-1:0] opnd(input logic [AW-1:0] p, input bit dbl);
      logic signed [31:0] v;
      if (dbl) v = {mem[p[9:0]], mem[10'(p + 1)]};
      else     v = 32'($signed(mem[p[9:0]]));
      return AC'(v);
   endfunction

   function automatic logic [AC-1:0] dot_sum(input logic [AW-1:0] ba, bb, input int n, input bit dbl);
      logic signed [AC-1:0] s = '0;
      for (int i = 0; i < n; i++) begin
         s = s + opnd(AW'(ba + i * (dbl ? 2 : 1)), dbl) * opnd(AW'(bb + i * (dbl ? 2 : 1)), dbl);
      end
      return s;
   endfunction

   function automatic logic [AC-1:0] poly_eval(input logic [AW-1:0] ba, input int n, input logic [DW-1:0] x);
      logic signed [AC-1:0] s = '0;
      logic signed [AC-1:0] xs = AC'($signed(x));
      for (int i = 0; i < n; i++) begin
         if (i == 0) s = opnd(ba, 1'b0);
         else s = s * xs + opnd(AW'(ba + i), 1'b0);
      end
      return s;
   endfunction

   // behavioural cycle model
   int m_state = 0;            // 0 idle, 1 running, 2 paused
   int m_setup = 0, m_ph = 0, m_rem = 0;
   bit m_first = 0, m_poly = 0, m_dbl = 0, m_done = 0;
   logic [AW-1:0] m_pa = '0, m_pb = '0;
   logic signed [AC-1:0] m_acc = '0;
   logic [DW-1:0] m_x = '0;

   function automatic int m_len();
      if (m_poly) return m_first ? 5 : 7;
      return m_dbl ? 16 : 8;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_setup = 0; m_ph = 0; m_rem = 0; m_first = 0;
         m_poly = 0; m_dbl = 0; m_done = 0; m_pa = '0; m_pb = '0; m_acc = '0; m_x = '0;
      end else begin
         m_done = 0;
         if (start && m_state != 1) begin
            m_state = 1; m_acc = '0; m_pa = base_a; m_pb = base_b;
            m_rem = int'(elem_count); m_first = 1; m_poly = mode_poly; m_dbl = prec_dbl; m_x = poly_x;
            if (mode_poly && elem_count != 0) begin m_setup = 0; m_ph = 5; end
            else begin m_setup = mode_poly ? 1 : 10; m_ph = 0; end
         end else if (m_state == 1) begin
            if (m_setup > 0) begin
               m_setup--;
               if (m_setup == 0) begin
                  if (m_rem == 0) begin m_state = 0; m_done = 1; end
                  else m_ph = m_len();
               end
            end else begin
               m_ph--;
               if (m_ph == 0) begin
                  if (m_poly) begin
                     if (m_first) m_acc = opnd(m_pa, 1'b0);
                     else m_acc = m_acc * AC'($signed(m_x)) + opnd(m_pa, 1'b0);
                     m_pa = m_pa + 1;
                  end else begin
                     m_acc = m_acc + opnd(m_pa, m_dbl) * opnd(m_pb, m_dbl);
                     m_pa = m_pa + (m_dbl ? 2 : 1);
                     m_pb = m_pb + (m_dbl ? 2 : 1);
                  end
                  m_rem--; m_first = 0;
                  if (m_rem == 0) begin m_state = 0; m_done = 1; end
                  else if (irq && !m_poly) m_state = 2;
                  else m_ph = m_len();
               end
            end
         end else if (m_state == 2 && resume) begin
            m_state = 1; m_ph = m_len();
         end
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         string tt;
         tt = m_poly ? "R9" : (m_dbl ? "R3" : "R2");
         chk(busy == (m_state == 1), tt, "busy", AC'(busy), AC'(m_state == 1));
         chk(done == m_done, tt, "done", AC'(done), AC'(m_done));
         chk(paused == (m_state == 2), "R6", "paused", AC'(paused), AC'(m_state == 2));
         chk(rem_count == m_rem[7:0], "R6", "rem_count", AC'(rem_count), AC'(m_rem[7:0]));
         chk(!(mem_rd && !busy), "R12", "read while idle", AC'(mem_rd), '0);
         if (m_state != 1) begin
            chk(acc == m_acc, m_poly ? "R9" : "R4", "acc", acc, m_acc);
            chk(ptr_a == m_pa, "R5", "ptr_a", AC'(ptr_a), AC'(m_pa));
            chk(ptr_b == m_pb, "R5", "ptr_b", AC'(ptr_b), AC'(m_pb));
         end
      end
   end

   task automatic kick(input bit pm, input bit pd, input int ba, input int bb, input int n, input int x);
      @(negedge clk);
      mode_poly = pm; prec_dbl = pd; base_a = AW'(ba); base_b = AW'(bb);
      elem_count = CW'(n); poly_x = DW'(x); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end(output int cyc);
      cyc = 0;
      while (!done && !paused) begin
         if (busy) cyc++;
         @(negedge clk);
      end
   endtask

   task automatic do_resume();
      @(negedge clk);
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c;
      for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503 + 12345 - (i % 7) * 3001);
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!busy && !done && !paused && !mem_rd, "R11", "flags", AC'({busy, done, paused, mem_rd}), '0);
      chk(acc == '0 && rem_count == '0 && ptr_a == '0 && ptr_b == '0, "R11", "state", acc, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // single precision, N=4
      kick(0, 0, 10, 200, 4, 0); wait_end(c);
      chk(c == 42, "R2", "busy clocks", AC'(c), AC'(42));
      chk(acc == dot_sum(10, 200, 4, 0), "R4", "single sum", acc, dot_sum(10, 200, 4, 0));
      chk(ptr_a == 14 && ptr_b == 204, "R5", "single ptr_a", AC'(ptr_a), AC'(14));

      // double precision, N=3, irq pulse inside setup is ignored
      kick(0, 1, 300, 400, 3, 0);
      repeat (4) @(negedge clk);
      irq = 1'b1; @(negedge clk); irq = 1'b0;
      wait_end(c); c = c + 5;
      chk(c == 58 && !paused, "R3", "busy clocks", AC'(c), AC'(58));
      chk(acc == dot_sum(300, 400, 3, 1), "R4", "double sum", acc, dot_sum(300, 400, 3, 1));
      chk(ptr_a == 306 && ptr_b == 406, "R5", "double ptr_a", AC'(ptr_a), AC'(306));

      // N=0 dot product
      kick(0, 0, 20, 30, 0, 0); wait_end(c);
      chk(c == 10, "R8", "zero-length busy", AC'(c), AC'(10));
      chk(acc == '0, "R8", "zero-length acc", acc, '0);

      // single, irq held: pause after element 1, then resume
      irq = 1'b1;
      kick(0, 0, 500, 600, 5, 0); wait_end(c);
      chk(paused && c == 18, "R6", "clocks to pause", AC'(c), AC'(18));
      chk(rem_count == 4 && ptr_a == 501 && ptr_b == 601, "R6", "saved rem", AC'(rem_count), AC'(4));
      irq = 1'b0;
      repeat (3) @(negedge clk);
      do_resume(); wait_end(c);
      chk(c == 32, "R7", "resume clocks", AC'(c), AC'(32));
      chk(acc == dot_sum(500, 600, 5, 0), "R7", "resumed sum", acc, dot_sum(500, 600, 5, 0));

      // double, irq kept through first resume: two pauses
      irq = 1'b1;
      kick(0, 1, 700, 800, 3, 0); wait_end(c);
      chk(paused && c == 26 && rem_count == 2, "R6", "double pause", AC'(c), AC'(26));
      do_resume(); wait_end(c);
      chk(paused && c == 16 && rem_count == 1, "R6", "second pause", AC'(c), AC'(16));
      chk(ptr_a == 704 && ptr_b == 804, "R5", "double saved ptr", AC'(ptr_a), AC'(704));
      irq = 1'b0;
      do_resume(); wait_end(c);
      chk(done && c == 16, "R7", "last resume clocks", AC'(c), AC'(16));
      chk(acc == dot_sum(700, 800, 3, 1), "R7", "double resumed sum", acc, dot_sum(700, 800, 3, 1));

      // polynomial with irq held high
      irq = 1'b1;
      kick(1, 1, 900, 0, 4, -3); wait_end(c);
      chk(!paused && c == 26, "R10", "poly not paused", AC'(paused), '0);
      chk(acc == poly_eval(900, 4, 16'hFFFD), "R9", "horner", acc, poly_eval(900, 4, 16'hFFFD));
      chk(ptr_a == 904, "R9", "poly ptr_a", AC'(ptr_a), AC'(904));
      irq = 1'b0;
      kick(1, 0, 950, 0, 1, 7); wait_end(c);
      chk(c == 5 && acc == poly_eval(950, 1, 16'd7), "R9", "poly N=1 clocks", AC'(c), AC'(5));
      kick(1, 0, 960, 0, 0, 7); wait_end(c);
      chk(c == 1 && acc == '0, "R8", "poly N=0", AC'(c), AC'(1));

      // start while busy is ignored
      kick(0, 0, 100, 150, 3, 0);
      repeat (12) @(negedge clk);
      elem_count = 8'd9; base_a = 16'd5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(rem_count == 3 && busy, "R1", "rem after busy start", AC'(rem_count), AC'(3));
      wait_end(c); c = c + 13;
      chk(c == 34, "R1", "busy clocks", AC'(c), AC'(34));
      chk(acc == dot_sum(100, 150, 3, 0), "R1", "sum unchanged", acc, dot_sum(100, 150, 3, 0));

      // start while paused launches a fresh operation
      irq = 1'b1;
      kick(0, 0, 40, 60, 4, 0); wait_end(c);
      irq = 1'b0;
      chk(paused, "R6", "paused before restart", AC'(paused), AC'(1));
      kick(0, 1, 620, 660, 2, 0);
      chk(busy && !paused, "R1", "restart from pause", AC'({busy, paused}), AC'(2'b10));
      wait_end(c);
      chk(c == 42, "R1", "restart clocks", AC'(c), AC'(42));
      chk(acc == dot_sum(620, 660, 2, 1), "R1", "restart sum", acc, dot_sum(620, 660, 2, 1));

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule